// File: doc/BRIEF.md
# Universal Bus Transceiver Register Path

This block carries one direction of a bidirectional bus transceiver from its A side to its B side. Its single storage element changes personality from cycle to cycle. With the latch enable high it is a transparent latch, and B follows A. With the latch enable low and the capture clock idle it holds its contents. With the latch enable low, a rising capture-clock edge loads A into the element. An active-low output enable decides whether B is driven.

A chip instantiates the block twice, one copy per direction. Each copy has its own enable, latch enable and capture clock. The whole block is synchronous to the system clock `clk_i`. The capture clock `ck_i` is a sampled level, and a rise counts as an edge when `clk_i` sees it low at one edge and high at the next. High impedance is modelled as a per-bit drive enable, with the data forced to zero while it is not driven.

Top module: `ubt_reg_path`

## Requirements
- R1: While `le_i` is high, `b_o` equals `a_i` in the same cycle, with no register in the path.
- R2: While `le_i` is low and `ck_i` stays low, the stored value does not change and `b_o` holds.
- R3: With `le_i` low, a sampled low-to-high change of `ck_i` loads `a_i` at that `clk_i` edge, and `b_o` shows it from then on.
- R4: With `le_i` low, a `ck_i` that stays high or falls loads nothing.
- R5: When `le_i` falls, the value held is the `a_i` sampled at the last `clk_i` edge on which `le_i` was high.
- R6: `oe_ni` high clears every bit of `b_oe_o` and drives `b_o` to zero. `oe_ni` low sets every bit of `b_oe_o`.
- R7: `oe_ni` has no effect on storage, so data captured while the outputs are disabled appears once they are enabled.
- R8: Reset clears the stored value to zero and treats `ck_i` as already high. A `ck_i` that is high when reset ends therefore causes no capture until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | A-side data |
| le_i | input | 1 | Latch enable, transparent when high |
| ck_i | input | 1 | Capture clock level, sampled on `clk_i` |
| oe_ni | input | 1 | Output enable, active low |
| b_o | output | WIDTH | B-side data, zero when not driven |
| b_oe_o | output | WIDTH | Per-bit drive enable for B |

## Verification
The bench builds the block at the default width of 18. At that width every bit of both nine-bit halves of a word is carried through random patterns, so an error that affects only some lanes shows up. Random latch-enable, capture-clock and enable sequences exercise all three storage modes and the transitions between them. Directed cases then pin down a falling latch enable, a capture clock held high, a capture made while the outputs are disabled, and a capture clock high as reset ends.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef enum logic [1:0] {
    UBT_HOLD    = 2'd0,
    UBT_PASS    = 2'd1,
    UBT_CAPTURE = 2'd2
  } ubt_mode_e;

  // Transparent wins over an edge seen in the same cycle
  function automatic ubt_mode_e ubt_decode(input logic le, input logic rise);
    if (le)        return UBT_PASS;
    else if (rise) return UBT_CAPTURE;
    else           return UBT_HOLD;
  endfunction
endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_i,
  output logic rise_o
);
  logic ck_q;

  // Reset to high: a level already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ck_q <= 1'b1;
    else         ck_q <= ck_i;
  end

  assign rise_o = ck_i & ~ck_q;
endmodule

// File: rtl/ubt_store.sv
module ubt_store
  import ubt_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ubt_mode_e        mode_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic load;
  assign load = (mode_i == UBT_PASS) || (mode_i == UBT_CAPTURE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (load) q_o <= d_i;
  end
endmodule

// File: rtl/ubt_out_drv.sv
module ubt_out_drv #(
  parameter int WIDTH = 18
) (
  input  logic             pass_i,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic sel;
    assign sel       = pass_i ? a_i[g] : q_i[g];
    assign b_oe_o[g] = ~oe_ni;
    assign b_o[g]    = sel & ~oe_ni;
  end
endmodule

// File: rtl/ubt_reg_path.sv
module ubt_reg_path
  import ubt_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic             le_i,
  input  logic             ck_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  logic             ck_rise;
  ubt_mode_e        mode;
  logic [WIDTH-1:0] store_q;

  ubt_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ck_i   (ck_i),
    .rise_o (ck_rise)
  );

  assign mode = ubt_decode(le_i, ck_rise);

  ubt_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .d_i    (a_i),
    .q_o    (store_q)
  );

  ubt_out_drv #(.WIDTH(WIDTH)) u_drv (
    .pass_i (mode == UBT_PASS),
    .oe_ni  (oe_ni),
    .a_i    (a_i),
    .q_i    (store_q),
    .b_o    (b_o),
    .b_oe_o (b_oe_o)
  );
endmodule

// File: rtl/ubt_reg_path_chk.sv
module ubt_reg_path_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic             le_i,
  input logic             ck_i,
  input logic             oe_ni,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] b_oe_o,
  input logic [WIDTH-1:0] store_q
);
  // R1
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !oe_ni) |-> (b_o == a_i));

  // R6
  out_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (b_oe_o == '0 && b_o == '0));

  // R6
  out_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (b_oe_o == '1));

  // R2
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !ck_i) |=> $stable(store_q));

  // R4
  no_level_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && ck_i && $past(ck_i)) |=> $stable(store_q));

  // R3
  edge_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !le_i && ck_i && !$past(ck_i)) |=> (store_q == $past(a_i)));

  // R5
  latch_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (store_q == $past(a_i)));

  // R8
  always_ff @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (store_q == '0);
  end
endmodule

bind ubt_reg_path ubt_reg_path_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .le_i    (le_i),
  .ck_i    (ck_i),
  .oe_ni   (oe_ni),
  .b_o     (b_o),
  .b_oe_o  (b_oe_o),
  .store_q (store_q)
);

// File: tb/ubt_reg_path_tb.sv
module ubt_reg_path_tb;
  localparam int W = 18;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0;
  logic         le_i = 1'b0;
  logic         ck_i = 1'b1;
  logic         oe_ni = 1'b0;
  logic [W-1:0] b_o, b_oe_o;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] m_store = '0;
  logic         m_ckp = 1'b1;

  always #10 clk_i = ~clk_i;

  ubt_reg_path #(.WIDTH(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .le_i(le_i),
    .ck_i(ck_i), .oe_ni(oe_ni), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  function automatic logic [W-1:0] exp_b(logic [W-1:0] a, logic le, logic oe_n,
                                         logic [W-1:0] st);
    if (oe_n) return '0;
    return le ? a : st;
  endfunction

  function automatic logic [W-1:0] exp_en(logic oe_n);
    return oe_n ? '0 : '1;
  endfunction

  task automatic check(string tag);
    logic [W-1:0] eb, ee;
    eb = exp_b(a_i, le_i, oe_ni, m_store);
    ee = exp_en(oe_ni);
    n_run++;
    if (b_o !== eb || b_oe_o !== ee) begin
      n_fail++;
      $display("FAIL %s: b=%h en=%h expected b=%h en=%h", tag, b_o, b_oe_o, eb, ee);
    end
  endtask

  // Drive on the falling edge, check mid-phase, then advance the model
  task automatic step(logic [W-1:0] a, logic le, logic ck, logic oe_n, string tag);
    @(negedge clk_i);
    a_i = a; le_i = le; ck_i = ck; oe_ni = oe_n;
    #5;
    check(tag);
    @(posedge clk_i);
    if (le) m_store = a;
    else if (ck && !m_ckp) m_store = a;
    m_ckp = ck;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #5;
    check("R8 reset value");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: ck high across reset release gives no capture
    step(18'h2A5A5, 1'b0, 1'b1, 1'b0, "R8 no edge at release");
    step(18'h13C3C, 1'b0, 1'b1, 1'b0, "R8 still zero");
    step(18'h13C3C, 1'b0, 1'b0, 1'b0, "R8 ck seen low");
    step(18'h0F0F0, 1'b0, 1'b1, 1'b0, "R3 first real edge");
    step(18'h00000, 1'b0, 1'b1, 1'b0, "R3 captured value");

    // R1 transparent
    step(18'h3FFFF, 1'b1, 1'b0, 1'b0, "R1 pass all ones");
    step(18'h15555, 1'b1, 1'b1, 1'b0, "R1 pass pattern");
    // R5 le falls
    step(18'h2AAAA, 1'b0, 1'b1, 1'b0, "R5 hold last passed");
    // R4 ck stays high, then falls
    step(18'h11111, 1'b0, 1'b1, 1'b0, "R4 ck high no load");
    step(18'h22222, 1'b0, 1'b0, 1'b0, "R4 ck fall no load");
    // R2 static low
    step(18'h33333, 1'b0, 1'b0, 1'b0, "R2 hold static");
    // R7 capture while disabled
    step(18'h1BEEF, 1'b0, 1'b1, 1'b1, "R6 disabled during capture");
    step(18'h00001, 1'b0, 1'b1, 1'b0, "R7 captured while disabled");
    step(18'h00002, 1'b1, 1'b0, 1'b1, "R6 disabled while transparent");

    for (int i = 0; i < 400; i++) begin
      logic le, ck, oe_n;
      string tag;
      v = W'($urandom);
      le = ($urandom % 10) < 3;
      ck = $urandom % 2;
      oe_n = ($urandom % 10) < 2;
      if (oe_n) tag = "R6 random";
      else if (le) tag = "R1 random";
      else if (ck && !m_ckp) tag = "R3 random";
      else tag = "R2 R4 random";
      step(v, le, ck, oe_n, tag);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule